// File: doc/BRIEF.md
# Learning Layer-2 Forwarding Engine

This block is the switching core for a small group of ports. Every port offers an input byte stream and receives an output byte stream. Each stream word is 9 bits wide: bits 7:0 carry a frame byte, and bit 8 is set only on the first byte of a frame. The engine visits the input streams in turn. It reads the 12-byte address header of a frame, which holds the destination address followed by the source address. It records the port that the source address arrived on, then sends the frame on.

The record of address locations is a small fully associative table with a configurable number of entries. When the engine knows the destination, the frame goes out on one port. When it does not know the destination, and for every group (multicast or broadcast) address, the frame goes out on every port except the one it came in on. The output streams are taken to be always ready. The egress port set is given by a one-bit-per-port valid vector that shares a single data bus.

Top module: `l2_fwd_engine`

## Requirements
- R1: The engine polls the input ports in round-robin order. It pops a word from a port only when that port's valid is high. A polled word with bit 8 clear is discarded and produces no output, and polling continues with the next port.
- R2: A polled word with bit 8 set starts a frame and is destination byte 0. The next eleven words from the same port are destination bytes 1 to 5 and source bytes 0 to 5, most significant byte first.
- R3: A source address that is not in the table is written into it, mapped to the ingress port.
- R4: A source address already held for a different port has its old entry cleared before the new mapping is written, so the table never holds the same address twice.
- R5: A unicast destination address that hits in the table is forwarded only on the port stored for it.
- R6: A destination address that misses in the table is forwarded on every port except the ingress port.
- R7: A destination whose group bit is 1 is always flooded to every port except the ingress port, even when the table holds that address. The group bit is bit 0 of destination byte 0.
- R8: Each forwarded frame is emitted in this order: the six destination bytes, the six source bytes, then the payload words in arrival order. Bit 8 is set on the first emitted byte and clear on every other byte.
- R9: Payload forwarding ends when the ingress port has no valid word, or when its next word has bit 8 set. That word is left unread, and the engine returns to polling.
- R10: Every table lookup produces, one cycle after the request, exactly one single-cycle pulse. The pulse is either a hit, carrying the entry index and port, or a miss.
- R11: New entries go into slots in order through a wrapping write pointer. When the table is full, the slot after the most recently written one is overwritten, and the address it held is forgotten.
- R12: After a port has been served, whether it was a discarded word or a whole frame, polling resumes at the next port in numeric order.
- R13: After reset no input word is popped, no output valid is raised, and the table holds no entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | NUM_PORTS*9 | Head word of each input stream; port p occupies bits 9p+8 down to 9p |
| in_valid | input | NUM_PORTS | Head word of the port is present |
| in_pop | output | NUM_PORTS | Consume the head word of the port at this clock edge |
| out_data | output | 9 | Egress word shared by all ports; bit 8 marks the first byte |
| out_valid | output | NUM_PORTS | Per-port strobe: the port takes out_data in this cycle |

## Verification
The bench builds the engine with three ports and a two-entry table. Three ports are enough to tell a single-port hit apart from a flood that skips the ingress port. They also let two ingress frames compete for a shared egress port, which makes the round-robin order visible. A two-entry table fills after two source addresses, so wrap-around overwriting, eviction of a learned destination, and moving an address to another port all occur within a few short frames. A group source address, learned and then used as a destination, shows that the group bit overrides a table hit.

// File: rtl/l2_fwd_pkg.sv
package l2_fwd_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = BYTE_W + 1;
  localparam int MAC_W     = 48;
  localparam int HDR_BYTES = 12;

  typedef enum logic [3:0] {
    S_HUNT,
    S_CAPTURE,
    S_SRC_LOOK,
    S_SRC_WAIT,
    S_DEL,
    S_LEARN,
    S_DST_LOOK,
    S_DST_WAIT,
    S_TX_HDR,
    S_TX_PAY
  } fwd_state_e;
endpackage

// File: rtl/l2_rr_pick.sv
module l2_rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] base,
  output logic [PW-1:0] gnt,
  output logic          any
);
  int idx;

  // Scan from the highest offset down so the lowest offset from base wins.
  always_comb begin
    any = 1'b0;
    gnt = base;
    idx = 0;
    for (int off = N - 1; off >= 0; off--) begin
      idx = (int'(base) + off) % N;
      if (req[idx]) begin
        any = 1'b1;
        gnt = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/l2_mac_table.sv
module l2_mac_table
  import l2_fwd_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 2,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [MAC_W-1:0] lk_key,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [IW-1:0]    lk_idx,
  output logic [PW-1:0]    lk_port,
  input  logic             del_en,
  input  logic [IW-1:0]    del_idx,
  input  logic             wr_en,
  input  logic [MAC_W-1:0] wr_key,
  input  logic [PW-1:0]    wr_port
);
  logic [DEPTH-1:0] ent_vld;
  logic [MAC_W-1:0] ent_key  [DEPTH];
  logic [PW-1:0]    ent_port [DEPTH];
  logic [IW-1:0]    wr_ptr_q, wr_ptr_n;
  logic [DEPTH-1:0] match_vec;
  logic [IW-1:0]    hit_idx;
  logic [PW-1:0]    hit_port;
  logic             any_match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = ent_vld[g] && (ent_key[g] == lk_key);
  end

  assign any_match = |match_vec;

  always_comb begin
    hit_idx  = '0;
    hit_port = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) begin
        hit_idx  = IW'(i);
        hit_port = ent_port[i];
      end
    end
  end

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    if (wr_en) wr_ptr_n = (wr_ptr_q == IW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      wr_ptr_q <= '0;
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_idx   <= '0;
      lk_port  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      lk_hit   <= lk_req & any_match;
      lk_miss  <= lk_req & ~any_match;
      if (lk_req) begin
        lk_idx  <= hit_idx;
        lk_port <= hit_port;
      end
      if (del_en) ent_vld[del_idx] <= 1'b0;
      if (wr_en)  ent_vld[wr_ptr_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key[wr_ptr_q]  <= wr_key;
      ent_port[wr_ptr_q] <= wr_port;
    end
  end

  AST_LOOKUP_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (lk_hit ^ lk_miss)); // R10
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !(lk_hit || lk_miss)); // R10
  AST_UNIQUE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> $onehot0(match_vec)); // R4
endmodule

// File: rtl/l2_fwd_engine.sv
module l2_fwd_engine
  import l2_fwd_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int TABLE_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*WORD_W-1:0] in_data,
  input  logic [NUM_PORTS-1:0]        in_valid,
  output logic [NUM_PORTS-1:0]        in_pop,
  output logic [WORD_W-1:0]           out_data,
  output logic [NUM_PORTS-1:0]        out_valid
);
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int IW = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1;
  localparam int CW = $clog2(HDR_BYTES);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [WORD_W-1:0] word_at [NUM_PORTS];
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_split
    assign word_at[g] = in_data[g*WORD_W +: WORD_W];
  end

  fwd_state_e           state_q, state_n;
  logic [PW-1:0]        ing_q, ing_n, rr_q, rr_n;
  logic [CW-1:0]        cnt_q, cnt_n;
  logic [NUM_PORTS-1:0] mask_q, mask_n;
  logic [IW-1:0]        del_q, del_n;
  logic [WORD_W-1:0]    out_data_q, out_data_n;
  logic [NUM_PORTS-1:0] out_valid_q, out_valid_n;
  logic [BYTE_W-1:0]    hdr_q [HDR_BYTES];
  logic                 hdr_we;
  logic [CW-1:0]        hdr_idx;
  logic [BYTE_W-1:0]    hdr_byte;

  logic [PW-1:0]     gnt;
  logic              gnt_any;
  logic [WORD_W-1:0] ing_word;
  logic              ing_valid;
  logic [MAC_W-1:0]  dst_mac, src_mac;
  logic              lk_req, lk_hit, lk_miss, del_en, wr_en;
  logic [MAC_W-1:0]  lk_key;
  logic [IW-1:0]     lk_idx;
  logic [PW-1:0]     lk_port;

  assign ing_word  = word_at[ing_q];
  assign ing_valid = in_valid[ing_q];
  assign dst_mac   = {hdr_q[0], hdr_q[1], hdr_q[2], hdr_q[3], hdr_q[4], hdr_q[5]};
  assign src_mac   = {hdr_q[6], hdr_q[7], hdr_q[8], hdr_q[9], hdr_q[10], hdr_q[11]};

  function automatic logic [PW-1:0] next_port(input logic [PW-1:0] p);
    return (p == PW'(NUM_PORTS - 1)) ? '0 : p + 1'b1;
  endfunction

  l2_rr_pick #(.N(NUM_PORTS), .PW(PW)) u_pick (
    .req (in_valid),
    .base(rr_q),
    .gnt (gnt),
    .any (gnt_any)
  );

  l2_mac_table #(.DEPTH(TABLE_DEPTH), .PW(PW), .IW(IW)) u_table (
    .clk    (clk),
    .rst_n  (rst_ni),
    .lk_req (lk_req),
    .lk_key (lk_key),
    .lk_hit (lk_hit),
    .lk_miss(lk_miss),
    .lk_idx (lk_idx),
    .lk_port(lk_port),
    .del_en (del_en),
    .del_idx(del_q),
    .wr_en  (wr_en),
    .wr_key (src_mac),
    .wr_port(ing_q)
  );

  always_comb begin
    state_n     = state_q;
    ing_n       = ing_q;
    rr_n        = rr_q;
    cnt_n       = cnt_q;
    mask_n      = mask_q;
    del_n       = del_q;
    out_data_n  = '0;
    out_valid_n = '0;
    in_pop      = '0;
    hdr_we      = 1'b0;
    hdr_idx     = cnt_q;
    hdr_byte    = ing_word[BYTE_W-1:0];
    lk_req      = 1'b0;
    lk_key      = dst_mac;
    del_en      = 1'b0;
    wr_en       = 1'b0;
    case (state_q)
      S_HUNT: if (gnt_any) begin
        in_pop[gnt] = 1'b1;
        rr_n        = next_port(gnt);
        if (word_at[gnt][BYTE_W]) begin
          hdr_we   = 1'b1;
          hdr_idx  = '0;
          hdr_byte = word_at[gnt][BYTE_W-1:0];
          ing_n    = gnt;
          cnt_n    = CW'(1);
          state_n  = S_CAPTURE;
        end
      end
      S_CAPTURE: if (ing_valid) begin
        if (ing_word[BYTE_W]) begin
          state_n = S_HUNT;
        end else begin
          in_pop[ing_q] = 1'b1;
          hdr_we        = 1'b1;
          cnt_n         = cnt_q + 1'b1;
          if (cnt_q == CW'(HDR_BYTES - 1)) state_n = S_SRC_LOOK;
        end
      end
      S_SRC_LOOK: begin
        lk_req  = 1'b1;
        lk_key  = src_mac;
        state_n = S_SRC_WAIT;
      end
      S_SRC_WAIT: begin
        if (lk_hit && lk_port == ing_q) begin
          state_n = S_DST_LOOK;
        end else if (lk_hit) begin
          del_n   = lk_idx;
          state_n = S_DEL;
        end else if (lk_miss) begin
          state_n = S_LEARN;
        end
      end
      S_DEL: begin
        del_en  = 1'b1;
        state_n = S_LEARN;
      end
      S_LEARN: begin
        wr_en   = 1'b1;
        state_n = S_DST_LOOK;
      end
      S_DST_LOOK: begin
        lk_req  = 1'b1;
        state_n = S_DST_WAIT;
      end
      S_DST_WAIT: if (lk_hit || lk_miss) begin
        mask_n  = (lk_hit && !hdr_q[0][0]) ? (NUM_PORTS'(1) << lk_port)
                                           : ~(NUM_PORTS'(1) << ing_q);
        cnt_n   = '0;
        state_n = S_TX_HDR;
      end
      S_TX_HDR: begin
        out_valid_n = mask_q;
        out_data_n  = {cnt_q == '0, hdr_q[cnt_q]};
        cnt_n       = cnt_q + 1'b1;
        if (cnt_q == CW'(HDR_BYTES - 1)) state_n = S_TX_PAY;
      end
      S_TX_PAY: begin
        if (ing_valid && !ing_word[BYTE_W]) begin
          in_pop[ing_q] = 1'b1;
          out_valid_n   = mask_q;
          out_data_n    = ing_word;
        end else begin
          state_n = S_HUNT;
        end
      end
      default: state_n = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_HUNT;
      ing_q       <= '0;
      rr_q        <= '0;
      cnt_q       <= '0;
      mask_q      <= '0;
      del_q       <= '0;
      out_data_q  <= '0;
      out_valid_q <= '0;
    end else begin
      state_q     <= state_n;
      ing_q       <= ing_n;
      rr_q        <= rr_n;
      cnt_q       <= cnt_n;
      mask_q      <= mask_n;
      del_q       <= del_n;
      out_data_q  <= out_data_n;
      out_valid_q <= out_valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (hdr_we) hdr_q[hdr_idx] <= hdr_byte;
  end

  assign out_data  = out_data_q;
  assign out_valid = out_valid_q;

  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(in_pop)); // R1
  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_pop & ~in_valid) == '0); // R1
  AST_FLOOD_SKIPS_INGRESS: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == S_TX_HDR || state_q == S_TX_PAY) && !$onehot(mask_q)) |-> !mask_q[ing_q]); // R6
  AST_HDR_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_TX_HDR && cnt_q == '0) |=> (out_data[BYTE_W] && out_valid != '0)); // R8
  AST_PAY_NO_START: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_TX_PAY && in_pop != '0) |=> !out_data[BYTE_W]); // R8
endmodule

// File: tb/l2_fwd_engine_test.sv
module l2_fwd_engine_test;
  localparam int NP = 3;
  localparam int TD = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP*9-1:0] in_data;
  logic [NP-1:0]   in_valid;
  logic [NP-1:0]   in_pop;
  logic [8:0]      out_data;
  logic [NP-1:0]   out_valid;

  always #4 clk = ~clk;

  l2_fwd_engine #(.NUM_PORTS(NP), .TABLE_DEPTH(TD)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_pop(in_pop), .out_data(out_data), .out_valid(out_valid)
  );

  logic [8:0] pq    [NP][$];
  logic [8:0] exp_q [NP][$];
  logic [NP-1:0] pend = '0;
  int    checks = 0;
  int    failures = 0;
  string cur_tag = "R13";
  bit    started = 1'b0;

  localparam logic [47:0] MAC_A = 48'h02_00_00_00_00_0A;
  localparam logic [47:0] MAC_B = 48'h02_00_00_00_00_0B;
  localparam logic [47:0] MAC_C = 48'h02_00_00_00_00_0C;
  localparam logic [47:0] MAC_G = 48'h03_00_00_00_00_11; // group bit set
  localparam logic [47:0] MAC_X = 48'h02_00_00_00_00_EE; // never learned
  localparam logic [47:0] MAC_M = 48'h01_00_5E_00_00_01; // group bit set

  // Input stream model: pops seen before an edge are applied after it.
  always begin
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      if (pend[p] && pq[p].size() > 0) void'(pq[p].pop_front());
    for (int p = 0; p < NP; p++) begin
      in_valid[p]       = (pq[p].size() > 0);
      in_data[p*9 +: 9] = (pq[p].size() > 0) ? pq[p][0] : 9'h000;
    end
    #2;
    pend = in_pop;
  end

  // Monitor: compare every egress word with the scoreboard.
  always @(negedge clk) begin
    if (started) begin
      for (int p = 0; p < NP; p++) begin
        if (out_valid[p]) begin
          checks++;
          if (exp_q[p].size() == 0) begin
            failures++;
            $display("FAIL %s port %0d unexpected word got %h exp none", cur_tag, p, out_data);
          end else begin
            logic [8:0] w;
            w = exp_q[p].pop_front();
            if (w !== out_data) begin
              failures++;
              $display("FAIL %s port %0d got %h exp %h", cur_tag, p, out_data, w);
            end
          end
        end
      end
    end
  end

  task automatic push_word(input int p, input logic [8:0] w, input logic [NP-1:0] to);
    pq[p].push_back(w);
    for (int q = 0; q < NP; q++) if (to[q]) exp_q[q].push_back(w);
  endtask

  // Driver: frame words go to the ingress queue and to each expected egress.
  task automatic send_frame(input int p, input logic [47:0] dst, input logic [47:0] src,
                            input int len, input int seed, input logic [NP-1:0] to);
    for (int i = 0; i < 6; i++) push_word(p, {i == 0, dst[47-8*i -: 8]}, to);
    for (int i = 0; i < 6; i++) push_word(p, {1'b0, src[47-8*i -: 8]}, to);
    for (int i = 0; i < len; i++) push_word(p, {1'b0, 8'(seed + i * 7)}, to);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      checks++;
      if (exp_q[p].size() != 0) begin
        failures++;
        $display("FAIL %s port %0d missing words got %0d left exp 0", cur_tag, p, exp_q[p].size());
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got running exp done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R13: idle after reset
    checks++;
    if (out_valid !== '0 || in_pop !== '0) begin
      failures++;
      $display("FAIL R13 got valid=%b pop=%b exp 0 0", out_valid, in_pop);
    end
    started = 1'b1;

    // R1: words without a start bit are consumed and dropped
    cur_tag = "R1";
    pq[1].push_back(9'h011);
    pq[1].push_back(9'h022);
    settle(30);
    checks++;
    if (pq[1].size() != 0) begin
      failures++;
      $display("FAIL R1 stray words left got %0d exp 0", pq[1].size());
    end

    // R2 R3 R6 R8: empty table, flood except ingress 0; learns A->0
    cur_tag = "R2 R3 R6 R8";
    send_frame(0, MAC_B, MAC_A, 3, 8'h30, 3'b110);
    settle(80);
    // R5 R10: A known on port 0; learns B->1
    cur_tag = "R5 R10";
    send_frame(1, MAC_A, MAC_B, 2, 8'h40, 3'b001);
    settle(80);
    // R4: A moves to port 2; B still on port 1
    cur_tag = "R4";
    send_frame(2, MAC_B, MAC_A, 1, 8'h50, 3'b010);
    settle(80);
    cur_tag = "R4 R5";
    send_frame(1, MAC_A, MAC_B, 2, 8'h60, 3'b100);
    settle(80);
    // R11: C overwrites B's slot; A still on port 2
    cur_tag = "R11";
    send_frame(0, MAC_A, MAC_C, 2, 8'h70, 3'b100);
    settle(80);
    cur_tag = "R11 R6";
    send_frame(2, MAC_B, MAC_A, 1, 8'h80, 3'b011);
    settle(80);
    // R11 R5: G overwrites A; C on port 0
    cur_tag = "R11 R5";
    send_frame(2, MAC_C, MAC_G, 2, 8'h90, 3'b001);
    settle(80);
    // R7: G is held for port 2 but is a group address
    cur_tag = "R7";
    send_frame(0, MAC_G, MAC_C, 2, 8'hA0, 3'b110);
    settle(80);
    // R9: back-to-back frames, first ends at the next start bit
    cur_tag = "R9";
    send_frame(2, MAC_C, MAC_G, 2, 8'hB0, 3'b001);
    send_frame(2, MAC_X, MAC_G, 3, 8'hC0, 3'b011);
    settle(120);
    // R12: after serving port 1, port 2 goes before port 0
    cur_tag = "R12";
    send_frame(1, MAC_M, MAC_B, 1, 8'hD0, 3'b101);
    settle(80);
    send_frame(2, MAC_M, MAC_G, 2, 8'hE0, 3'b011);
    send_frame(0, MAC_M, MAC_A, 2, 8'hF0, 3'b110);
    settle(120);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule